// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Counter

This block is a 4-bit synchronous counter. A run-time mode input selects either pure binary counting over the full range of the width or decimal (BCD digit) counting from 0 to 9. A second input sets the direction, up or down. An active-low carry input acts as a count enable. A level-sensitive load input forces the output to a parallel value at once, without waiting for the clock.

The active-low carry output reports the terminal count for the current direction and mode. It is gated by the carry input and is purely combinational. The carry output of one stage can therefore drive the carry input of the next when all stages share one clock. This is how wider binary counters or multi-digit decimal counters are built.

Top module: `updn_jam_counter`

## Requirements
- R1: While `loadEn` is 1, `count` equals `loadVal` within the same cycle, with no clock edge needed, and it follows changes of `loadVal`.
- R2: Loading `loadVal` = 0 forces `count` to 0, and the value stays after `loadEn` returns to 0 while counting is disabled.
- R3: On a rising clock edge, `count` does not change if `carryInN` is 1 or `loadEn` is 1. It advances by one step only when both are 0.
- R4: With `binaryMode` = 1 and `countUp` = 1, each step adds one, and 15 wraps to 0.
- R5: With `binaryMode` = 1 and `countUp` = 0, each step subtracts one, and 0 wraps to 15.
- R6: With `binaryMode` = 0, counting up goes from 9 to 0, and counting down goes from 0 to 9. A count starting in 0..9 stays in 0..9.
- R7: With `binaryMode` = 0, a count loaded in the range 10..15 goes to 0 on the next up step. On a down step it decrements by one.
- R8: `carryOutN` is 0 exactly when `carryInN` is 0 and `count` is at the terminal value, in the same cycle. The terminal value is 15 when counting up in binary mode, 9 when counting up in decade mode, and 0 when counting down. Otherwise `carryOutN` is 1.
- R9: Two stages on one clock, with the low stage's `carryOutN` wired to the high stage's `carryInN`, count as one 8-bit binary counter or as a two-digit decimal counter, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| carryInN | input | 1 | Active-low carry in / count enable |
| binaryMode | input | 1 | 1 = binary counting, 0 = decade counting |
| countUp | input | 1 | 1 = count up, 0 = count down |
| loadEn | input | 1 | Asynchronous, level-sensitive parallel load |
| loadVal | input | 4 | Parallel load value |
| count | output | 4 | Present count |
| carryOutN | output | 1 | Active-low terminal-count flag, gated by carryInN |

## Verification
On every cycle, the assertions check four things: the load path is transparent, the count holds whenever stepping is inhibited, the carry output stays high while the carry input is high, and decade counting stays in 0..9 and sends an out-of-range value to 0 on an up step. Only the bench scenarios can show the actual wrap values for each mode and direction, the exact carry-out timing at each terminal value, the down-step behaviour from out-of-range decade values, and the two-stage cascade as binary and as decimal.

// File: rtl/updn_pkg.sv
package updn_pkg;
  // Strobes sent from the control decode to the count register
  typedef struct packed {
    logic advance;     // take one step at this clock edge
    logic up;          // direction of the step
    logic decade;      // decade range selected
    logic wrapToZero;  // up step leaves the top of the range
    logic wrapToTop;   // down step leaves zero
  } stepCtl_t;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int DECADE_LAST = 9
) (
  input  logic             clk,
  input  logic             loadEn,
  input  logic             carryInN,
  input  logic             binaryMode,
  input  logic             countUp,
  input  logic [WIDTH-1:0] count,
  output stepCtl_t         ctl,
  output logic             carryOutN
);
  localparam logic [WIDTH-1:0] BinTop = '1;
  localparam logic [WIDTH-1:0] DecTop = DECADE_LAST[WIDTH-1:0];
  localparam logic [WIDTH-1:0] Zero   = '0;

  logic atUpTop, atBottom, atTerminal;

  always_comb begin
    atUpTop    = binaryMode ? (count == BinTop) : (count == DecTop);
    atBottom   = (count == Zero);
    atTerminal = countUp ? atUpTop : atBottom;
    carryOutN  = !(!carryInN && atTerminal);

    ctl.advance    = !carryInN && !loadEn;
    ctl.up         = countUp;
    ctl.decade     = !binaryMode;
    ctl.wrapToZero = countUp && (binaryMode ? (count == BinTop) : (count >= DecTop));
    ctl.wrapToTop  = !countUp && atBottom;
  end

  AST_CARRY_IDLE_HIGH: assert property (@(posedge clk) carryInN |-> carryOutN); // R8
endmodule

// File: rtl/updn_datapath.sv
module updn_datapath
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int DECADE_LAST = 9
) (
  input  logic             clk,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadVal,
  input  stepCtl_t         ctl,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] BinTop = '1;
  localparam logic [WIDTH-1:0] DecTop = DECADE_LAST[WIDTH-1:0];
  localparam logic [WIDTH-1:0] One    = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cntReg, nextVal;

  always_comb begin
    if (ctl.wrapToZero)     nextVal = '0;
    else if (ctl.wrapToTop) nextVal = ctl.decade ? DecTop : BinTop;
    else if (ctl.up)        nextVal = cntReg + One;
    else                    nextVal = cntReg - One;
  end

  // Register loads on the rising edge of loadEn and on every clock while it is held
  always_ff @(posedge clk or posedge loadEn) begin
    if (loadEn)           cntReg <= loadVal;
    else if (ctl.advance) cntReg <= nextVal;
  end

  // Transparent view of the load value while loading
  assign count = loadEn ? loadVal : cntReg;

  AST_PRESET_TRANSPARENT: assert property (@(posedge clk) loadEn |-> count == loadVal); // R1
  AST_HOLD_INHIBITED: assert property (@(posedge clk) disable iff (loadEn)
    !ctl.advance |=> count == $past(count)); // R3
  AST_DECADE_IN_RANGE: assert property (@(posedge clk) disable iff (loadEn)
    (ctl.advance && ctl.decade && count <= DecTop) |=> count <= DecTop); // R6
  AST_DECADE_OOR_UP: assert property (@(posedge clk) disable iff (loadEn)
    (ctl.advance && ctl.decade && ctl.up && count > DecTop) |=> count == '0); // R7
endmodule

// File: rtl/updn_jam_counter.sv
module updn_jam_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int DECADE_LAST = 9
) (
  input  logic             clk,
  input  logic             carryInN,
  input  logic             binaryMode,
  input  logic             countUp,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] count,
  output logic             carryOutN
);
  stepCtl_t ctl;

  updn_ctrl #(.WIDTH(WIDTH), .DECADE_LAST(DECADE_LAST)) uCtrl (
    .clk(clk), .loadEn(loadEn), .carryInN(carryInN), .binaryMode(binaryMode),
    .countUp(countUp), .count(count), .ctl(ctl), .carryOutN(carryOutN)
  );

  updn_datapath #(.WIDTH(WIDTH), .DECADE_LAST(DECADE_LAST)) uData (
    .clk(clk), .loadEn(loadEn), .loadVal(loadVal), .ctl(ctl), .count(count)
  );
endmodule

// File: tb/tb_updn_jam_counter.sv
module tb_updn_jam_counter;
  logic clk = 1'b0;
  logic carryInN = 1'b1, binaryMode = 1'b1, countUp = 1'b1, loadEn = 1'b1;
  logic [3:0] loadVal = 4'd0, hiLoad = 4'd0;
  logic [3:0] count, hiCount;
  logic carryOutN, hiCarryN;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  updn_jam_counter dut (
    .clk(clk), .carryInN(carryInN), .binaryMode(binaryMode), .countUp(countUp),
    .loadEn(loadEn), .loadVal(loadVal), .count(count), .carryOutN(carryOutN)
  );

  // Upper stage of the cascade, enabled by the lower stage's carry
  updn_jam_counter hiStage (
    .clk(clk), .carryInN(carryOutN), .binaryMode(binaryMode), .countUp(countUp),
    .loadEn(loadEn), .loadVal(hiLoad), .count(hiCount), .carryOutN(hiCarryN)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic doPreset(input logic [3:0] v);
    loadEn = 1'b1; loadVal = v;
    tick();
    loadEn = 1'b0;
    #1;
  endtask

  task automatic testReset();
    carryInN = 1'b1; loadVal = 4'd0; loadEn = 1'b1;
    tick(); tick();
    chk("R2 load zero", count, 0);
    loadEn = 1'b0;
    tick(); tick();
    chk("R2 zero held after release", count, 0);
    chk("R8 carry high while carryInN high", carryOutN, 1);
  endtask

  task automatic testTransparent();
    loadEn = 1'b1; loadVal = 4'd5; #1;
    chk("R1 transparent load 5", count, 5);
    loadVal = 4'd11; #1;
    chk("R1 follows load 11", count, 11);
    tick();
    loadEn = 1'b0; #1;
    chk("R1 value kept after release", count, 11);
  endtask

  task automatic testInhibit();
    binaryMode = 1'b1; countUp = 1'b1;
    doPreset(4'd6);
    carryInN = 1'b1;
    tick(); tick(); tick();
    chk("R3 hold with carryInN high", count, 6);
    carryInN = 1'b0; loadEn = 1'b1; loadVal = 4'd7;
    tick(); tick();
    chk("R3 hold while loading", count, 7);
    loadEn = 1'b0;
    tick();
    chk("R3 steps once enabled", count, 8);
    carryInN = 1'b1;
  endtask

  task automatic testBinUp();
    binaryMode = 1'b1; countUp = 1'b1;
    doPreset(4'd13);
    carryInN = 1'b0;
    tick(); chk("R4 13->14", count, 14);
    tick(); chk("R4 14->15", count, 15);
    tick(); chk("R4 15 wraps to 0", count, 0);
    tick(); chk("R4 0->1", count, 1);
    carryInN = 1'b1;
  endtask

  task automatic testBinDown();
    binaryMode = 1'b1; countUp = 1'b0;
    doPreset(4'd2);
    carryInN = 1'b0;
    tick(); chk("R5 2->1", count, 1);
    tick(); chk("R5 1->0", count, 0);
    tick(); chk("R5 0 wraps to 15", count, 15);
    tick(); chk("R5 15->14", count, 14);
    carryInN = 1'b1;
  endtask

  task automatic testDecade();
    binaryMode = 1'b0; countUp = 1'b1;
    doPreset(4'd7);
    carryInN = 1'b0;
    tick(); chk("R6 7->8", count, 8);
    tick(); chk("R6 8->9", count, 9);
    tick(); chk("R6 9 wraps to 0", count, 0);
    carryInN = 1'b1;
    countUp = 1'b0;
    doPreset(4'd1);
    carryInN = 1'b0;
    tick(); chk("R6 down 1->0", count, 0);
    tick(); chk("R6 down 0 wraps to 9", count, 9);
    tick(); chk("R6 down 9->8", count, 8);
    carryInN = 1'b1;
  endtask

  task automatic testDecadeOutOfRange();
    binaryMode = 1'b0; countUp = 1'b1;
    doPreset(4'd12);
    carryInN = 1'b0;
    tick(); chk("R7 up from 12 to 0", count, 0);
    carryInN = 1'b1; countUp = 1'b0;
    doPreset(4'd12);
    carryInN = 1'b0;
    tick(); chk("R7 down 12->11", count, 11);
    tick(); chk("R7 down 11->10", count, 10);
    tick(); chk("R7 down 10->9", count, 9);
    carryInN = 1'b1;
  endtask

  task automatic testCarry();
    binaryMode = 1'b1; countUp = 1'b1;
    doPreset(4'd15);
    carryInN = 1'b0; #1;
    chk("R8 binary up at 15 low", carryOutN, 0);
    carryInN = 1'b1; #1;
    chk("R8 gated by carryInN", carryOutN, 1);
    doPreset(4'd9);
    carryInN = 1'b0; #1;
    chk("R8 binary up at 9 high", carryOutN, 1);
    binaryMode = 1'b0; #1;
    chk("R8 decade up at 9 low", carryOutN, 0);
    countUp = 1'b0; #1;
    chk("R8 down at 9 high", carryOutN, 1);
    carryInN = 1'b1;
    doPreset(4'd0);
    carryInN = 1'b0; #1;
    chk("R8 down at 0 low", carryOutN, 0);
    carryInN = 1'b1;
  endtask

  task automatic testCascade();
    binaryMode = 1'b1; countUp = 1'b1;
    hiLoad = 4'd3; doPreset(4'd14);
    carryInN = 1'b0;
    tick(); tick();
    chk("R9 binary cascade 0x3E+2", {hiCount, count}, 8'h40);
    carryInN = 1'b1;
    binaryMode = 1'b0;
    hiLoad = 4'd2; doPreset(4'd8);
    carryInN = 1'b0;
    tick(); tick(); tick();
    chk("R9 decimal cascade 28+3", {hiCount, count}, 8'h31);
    countUp = 1'b0;
    tick(); tick();
    chk("R9 decimal cascade 31-2", {hiCount, count}, 8'h29);
    carryInN = 1'b1;
  endtask

  initial begin
    testReset();
    testTransparent();
    testInhibit();
    testBinUp();
    testBinDown();
    testDecade();
    testDecadeOutOfRange();
    testCarry();
    testCascade();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule